// File: doc/BRIEF.md
# Eight-bit timer/counter with prescaler

This peripheral keeps an 8-bit up-count for a small processor core. It takes its count source from one of two places. In timer mode it counts a strobe that marks each instruction cycle. In counter mode it counts edges on an external event pin, and the pin passes through a synchronizer first. Either source can feed the count directly, or it can go through a power-of-two prescaler.

Software loads the count through a write port. After each load, counting is held off for the next two instruction cycles. The count wraps from 0xFF to 0x00, and the wrap sets a sticky overflow flag. A write to the count clears that flag.

The control byte selects the following:
- the source, on bit 5;
- the active event edge, on bit 4;
- whether the prescaler is used, on bit 3;
- the prescale ratio, on bits 2:0.

Top module: `evt_timer8`

## Requirements
- R1: On synchronous reset the count reads 0x00, the overflow flag reads 0, and the control byte reads 0xFF.
- R2: With control bit 5 = 0 (instruction-cycle source) and bit 3 = 0 (no prescaler), each `cyc_stb` pulse advances the count by one. The new value is visible after the clock edge that samples the pulse.
- R3: A count write loads `cnt_wdata` at the next edge. The two `cyc_stb` pulses that follow produce no increment. The third pulse increments from the written value.
- R4: With bit 3 = 1, a field value p in bits 2:0 gives a ratio N = 2^(p+1), from 1:2 for p=0 to 1:256 for p=7. The count advances once per N source ticks. A count write clears the prescaler, so the first increment after the hold-off comes on the N-th tick.
- R5: With bit 5 = 1 and bit 4 = 0, each rising edge on `evt_in` counts once, and falling edges do not count. A level change that is set up before edge k is counted at edge k+2.
- R6: With bit 5 = 1 and bit 4 = 1, each falling edge on `evt_in` counts once, and rising edges do not count.
- R7: In timer mode, activity on `evt_in` has no effect on the count. In counter mode, `cyc_stb` pulses have no effect on the count apart from ending the hold-off.
- R8: An increment from 0xFF to 0x00 sets `ovf_flag`. The flag stays set through later increments and is cleared by a count write.
- R9: A count write and a source tick in the same cycle: the write wins, and that tick is not counted.
- R10: A control write is returned unchanged on `ctl_q` from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One-clock pulse per instruction cycle |
| evt_in | input | 1 | External event pin, asynchronous |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | New control byte |
| cnt_q | output | 8 | Current count, readable with no side effects |
| ctl_q | output | 8 | Current control byte |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Each result has its own latency:
- Writes and strobe-driven increments show one clock edge after they are sampled.
- An event-pin change takes the synchronizer pair plus the edge register, so it lands on the third edge after it is applied.

The driver changes inputs just after the falling clock edge and advances whole clock cycles. It then queues the expected count, flag and control byte, and the monitor compares them shortly after that falling edge, when every register has settled. For the event path, one check samples the cycle just before the count is due and another samples the cycle when it is due, which pins the latency exactly. The other event checks wait four cycles.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CNT_W    = 8;
    localparam int PS_W     = 3;
    localparam int HOLD_CYC = 2;
    localparam int SYNC_STG = 2;

    typedef enum logic {
        SRC_CYCLE = 1'b0,
        SRC_EVENT = 1'b1
    } tmr_src_e;

    typedef struct packed {
        logic [1:0]      spare;
        tmr_src_e        src;
        logic            edge_fall;
        logic            use_presc;
        logic [PS_W-1:0] ratio;
    } tmr_ctl_t;

    localparam logic [7:0] CTL_RST = 8'hFF;

    // terminal-count mask of the prescaler: N-1 with N = 2^(ratio+1)
    function automatic logic [CNT_W-1:0] presc_mask(input logic [PS_W-1:0] ratio);
        logic [CNT_W:0] n;
        n = (CNT_W+1)'(2) << ratio;
        return CNT_W'(n - 1'b1);
    endfunction

endpackage

// File: rtl/tmr8_evsync.sv
module tmr8_evsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_in,
    input  logic fall_sel,
    output logic ev_tick
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], evt_in};
    end

    logic lvl_now, lvl_old;
    assign lvl_now = sh[STAGES-1];
    assign lvl_old = sh[STAGES];

    always_comb begin
        if (fall_sel) ev_tick = lvl_old & ~lvl_now;
        else          ev_tick = lvl_now & ~lvl_old;
    end

    // R5 / R6: one pin edge gives a single-cycle tick while the edge choice is steady
    a_r5_single_tick: assert property (@(posedge clk) disable iff (rst)
        ev_tick |=> (!ev_tick || fall_sel != $past(fall_sel)));

endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
    parameter int W    = 8,
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    input  logic [PS_W-1:0] ratio,
    output logic            tick_out
);
    logic [W-1:0] pcnt;
    logic [W-1:0] mask;
    logic         term;

    assign mask     = tmr8_pkg::presc_mask(ratio);
    assign term     = ((pcnt | ~mask) == {W{1'b1}});
    assign tick_out = tick & term;

    always_ff @(posedge clk) begin
        if (rst || clr)  pcnt <= '0;
        else if (tick)   pcnt <= term ? '0 : pcnt + 1'b1;
    end

    // R4: a freshly cleared prescaler never emits on the following cycle
    a_r4_no_early_tick: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !tick_out);

endmodule

// File: rtl/tmr8_holdoff.sv
module tmr8_holdoff #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cyc_stb,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                      left <= '0;
        else if (load)                left <= HW'(HOLD);
        else if (cyc_stb && busy)     left <= left - 1'b1;
    end

    assign busy = (left != '0);

    // R3: a load always opens a hold-off window
    a_r3_busy_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> busy);

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_stb,
    input  logic             evt_in,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [7:0]       ctl_q,
    output logic             ovf_flag
);
    tmr_ctl_t         ctl_r;
    logic             ev_tick, busy, src_tick, gated, presc_out, inc;
    logic [CNT_W-1:0] cnt_r;
    logic             ovf_r;

    always_ff @(posedge clk) begin
        if (rst)         ctl_r <= tmr_ctl_t'(CTL_RST);
        else if (ctl_wr) ctl_r <= tmr_ctl_t'(ctl_wdata);
    end

    tmr8_evsync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (evt_in),
        .fall_sel (ctl_r.edge_fall),
        .ev_tick  (ev_tick)
    );

    tmr8_holdoff #(.HOLD(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_wr),
        .cyc_stb (cyc_stb),
        .busy    (busy)
    );

    assign src_tick = (ctl_r.src == SRC_EVENT) ? ev_tick : cyc_stb;
    assign gated    = src_tick & ~busy & ~cnt_wr;

    tmr8_presc #(.W(CNT_W), .PS_W(PS_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_wr),
        .tick     (gated & ctl_r.use_presc),
        .ratio    (ctl_r.ratio),
        .tick_out (presc_out)
    );

    assign inc = ctl_r.use_presc ? presc_out : gated;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_r <= '0;
            ovf_r <= 1'b0;
        end else if (cnt_wr) begin
            cnt_r <= cnt_wdata;
            ovf_r <= 1'b0;
        end else if (inc) begin
            cnt_r <= cnt_r + 1'b1;
            if (cnt_r == {CNT_W{1'b1}}) ovf_r <= 1'b1;
        end
    end

    assign cnt_q    = cnt_r;
    assign ctl_q    = ctl_r;
    assign ovf_flag = ovf_r;

    // R2: without a write the count moves by at most one per cycle
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R3: no advance while the hold-off is open
    a_r3_hold_still: assert property (@(posedge clk) disable iff (rst)
        (busy && !cnt_wr) |=> cnt_q == $past(cnt_q));

    // R8: the flag survives anything but a count write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !cnt_wr) |=> ovf_flag);

    // R8: leaving 0xFF without a write raises the flag
    a_r8_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}} || ovf_flag));

    // R9: a write always lands, whatever tick coincides with it
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(cnt_wdata) && !ovf_flag));

endmodule

// File: tb/tb_evt_timer8.sv
module tb_evt_timer8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_stb = 1'b0;
    logic       evt_in = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] cnt_q, ctl_q;
    logic       ovf_flag;

    always #4 clk = ~clk;   // 8 ns period

    evt_timer8 dut (
        .clk       (clk),
        .rst       (rst),
        .cyc_stb   (cyc_stb),
        .evt_in    (evt_in),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .cnt_q     (cnt_q),
        .ctl_q     (ctl_q),
        .ovf_flag  (ovf_flag)
    );

    typedef struct {
        string      tag;
        logic [7:0] cnt;
        logic       ovf;
        logic [7:0] ctl;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 0;
    logic [7:0] ctl_m = 8'hFF;

    // monitor: compare queued expectations just after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (cnt_q !== e.cnt || ovf_flag !== e.ovf || ctl_q !== e.ctl) begin
                n_err++;
                $display("FAIL %s: cnt=%h ovf=%b ctl=%h expected cnt=%h ovf=%b ctl=%h",
                         e.tag, cnt_q, ovf_flag, ctl_q, e.cnt, e.ovf, e.ctl);
            end
        end
    end

    task automatic expect_now(input string tag, input logic [7:0] c, input logic o);
        exp_t e;
        e.tag = tag; e.cnt = c; e.ovf = o; e.ctl = ctl_m;
        sb_q.push_back(e);
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_m  = v;
    endtask

    task automatic stb(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_stb = 1'b1;
            @(negedge clk);
            cyc_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pin(input logic v);
        evt_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: cnt=%h ovf=%b expected run to finish", cnt_q, ovf_flag);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 reset", 8'h00, 1'b0);

        // timer source, direct
        wr_ctl(8'h00);
        expect_now("R10 ctl readback", 8'h00, 1'b0);
        wr_cnt(8'h10);  expect_now("R3 load", 8'h10, 1'b0);
        stb(1);         expect_now("R3 hold 1", 8'h10, 1'b0);
        stb(1);         expect_now("R3 hold 2", 8'h10, 1'b0);
        stb(1);         expect_now("R3 resume", 8'h11, 1'b0);
        stb(3);         expect_now("R2 per cycle", 8'h14, 1'b0);
        pin(1'b1); pin(1'b0);
        expect_now("R7 pin ignored in timer mode", 8'h14, 1'b0);

        // write and strobe in the same cycle
        cnt_wr = 1'b1; cnt_wdata = 8'h20; cyc_stb = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0; cyc_stb = 1'b0;
        expect_now("R9 write wins", 8'h20, 1'b0);
        stb(2);         expect_now("R9 hold", 8'h20, 1'b0);
        stb(1);         expect_now("R9 resume", 8'h21, 1'b0);

        // prescaler 1:4
        wr_ctl(8'h09);
        wr_cnt(8'h30);
        stb(2);         expect_now("R4 hold 1:4", 8'h30, 1'b0);
        stb(3);         expect_now("R4 three ticks 1:4", 8'h30, 1'b0);
        stb(1);         expect_now("R4 fourth tick 1:4", 8'h31, 1'b0);
        stb(4);         expect_now("R4 next period 1:4", 8'h32, 1'b0);

        // prescaler 1:2
        wr_ctl(8'h08);
        wr_cnt(8'h40);
        stb(2);         expect_now("R4 hold 1:2", 8'h40, 1'b0);
        stb(1);         expect_now("R4 first tick 1:2", 8'h40, 1'b0);
        stb(1);         expect_now("R4 second tick 1:2", 8'h41, 1'b0);
        stb(4);         expect_now("R4 run 1:2", 8'h43, 1'b0);

        // prescaler 1:256, a long run
        wr_ctl(8'h0F);
        wr_cnt(8'h50);
        stb(2);
        stb(255);       expect_now("R4 255 ticks 1:256", 8'h50, 1'b0);
        stb(1);         expect_now("R4 256th tick 1:256", 8'h51, 1'b0);

        // wrap
        wr_ctl(8'h00);
        wr_cnt(8'hFE);
        stb(2);         expect_now("R8 hold", 8'hFE, 1'b0);
        stb(1);         expect_now("R8 at top", 8'hFF, 1'b0);
        stb(1);         expect_now("R8 wrap sets flag", 8'h00, 1'b1);
        stb(2);         expect_now("R8 sticky", 8'h02, 1'b1);
        wr_cnt(8'h05);  expect_now("R8 write clears", 8'h05, 1'b0);

        // event source, rising edge
        wr_ctl(8'h20);
        stb(2);         expect_now("R7 strobes ignored in counter mode", 8'h05, 1'b0);
        evt_in = 1'b1;
        @(negedge clk);
        @(negedge clk); expect_now("R5 not yet", 8'h05, 1'b0);
        @(negedge clk); expect_now("R5 counted at k+2", 8'h06, 1'b0);
        @(negedge clk);
        pin(1'b0);      expect_now("R5 falling ignored", 8'h06, 1'b0);
        pin(1'b1);      expect_now("R5 rising again", 8'h07, 1'b0);
        pin(1'b0);

        // event source, falling edge
        wr_ctl(8'h30);
        pin(1'b1);      expect_now("R6 rising ignored", 8'h07, 1'b0);
        pin(1'b0);      expect_now("R6 falling counted", 8'h08, 1'b0);

        // event source through prescaler 1:2
        wr_ctl(8'h38);
        pin(1'b1); pin(1'b0);
        expect_now("R4 event first of two", 8'h08, 1'b0);
        pin(1'b1); pin(1'b0);
        expect_now("R4 event second of two", 8'h09, 1'b0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule